// File: doc/BRIEF.md
# Isochronous IN Endpoint Frame Scheduler

This block governs a single isochronous IN endpoint of a full-speed USB device. Firmware loads a transfer size, a packet count, a per-frame packet limit, a maximum packet size and a transmit FIFO number, and chooses whether the endpoint fires in an even or an odd frame. Arming normally happens one frame ahead: to send in frame n, firmware enables the endpoint during frame n-1.

The block samples the frame number on each SOF strobe and answers an IN token only when bit 0 of that number equals the chosen parity. When the FIFO holds enough bytes, it issues a one-cycle send request with the packet length and decrements its byte and packet counters. Sending the last packet raises a transfer-complete flag. If a frame ends while the parity matches and the endpoint is still enabled, the block raises an incomplete-isochronous flag instead of dropping the frame silently. This covers a frame with no token, a token that arrived before the FIFO was filled, and a token that had an error. Both events disable the endpoint. Each flag is write-1-to-clear and has its own interrupt mask.

Top module: `iso_in_sched`

## Requirements
- R1: After reset the endpoint is disabled, both flags are 0, both interrupts are low and no send request is active.
- R2: A write with set-even makes the target parity 0, and a write with set-odd makes it 1; set-even wins if both are set. A token is answered only if the target parity equals bit 0 of the frame number captured on the latest SOF strobe, and that number is shown on `cur_frame_o`.
- R3: A token gets no packet unless the endpoint is enabled, marked active, typed isochronous (type code 1) and has had its NAK state cleared by a clear-NAK write. NAK is set after reset.
- R4: An accepted token gives `pkt_send_o` high for one cycle after the token cycle. The length is the whole remaining byte count on the last packet, and otherwise the smaller of the remaining bytes and the maximum packet size. The remaining bytes drop by that length and the remaining packets drop by one.
- R5: A token with an error, or a token that arrives while the FIFO byte count is below the packet length, sends nothing and leaves the counters and the enable unchanged.
- R6: Sending the last packet sets flag bit 0 (transfer complete) and clears the enable.
- R7: At most max(mc,1) packets are sent in one frame. Any further tokens in that frame are ignored.
- R8: On an SOF strobe, if the endpoint is enabled and its parity equals the parity of the frame that is ending, flag bit 1 (incomplete) is set and the enable is cleared. Otherwise the enable is kept.
- R9: Writing 1 to an `int_clr_i` bit clears that flag. A set event in the same cycle wins.
- R10: `xfer_irq_o` equals flag bit 0 AND mask bit 0, and `incomp_irq_o` equals flag bit 1 AND mask bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Arm/configure write strobe |
| cfg_enable_i | input | 1 | Endpoint enable value |
| cfg_active_i | input | 1 | Endpoint active value |
| cfg_cnak_i | input | 1 | Clear NAK state |
| cfg_set_even_i | input | 1 | Target even frames |
| cfg_set_odd_i | input | 1 | Target odd frames |
| cfg_ep_type_i | input | 2 | Endpoint type, 1 = isochronous |
| cfg_fifo_id_i | input | FIFO_ID_W | Transmit FIFO number |
| cfg_mps_i | input | MPS_W | Maximum packet size |
| cfg_xfer_size_i | input | XFER_W | Transfer size in bytes |
| cfg_pkt_cnt_i | input | PKT_W | Packet count |
| cfg_mc_i | input | MC_W | Packets allowed per frame |
| sof_i | input | 1 | SOF strobe |
| frame_num_i | input | FN_W | Frame number, valid with sof_i |
| in_token_i | input | 1 | IN token strobe for this endpoint |
| in_token_err_i | input | 1 | Token had an error |
| fifo_bytes_i | input | XFER_W | Bytes present in transmit FIFO |
| int_mask_i | input | 2 | Interrupt masks, bit0 complete, bit1 incomplete |
| int_clr_i | input | 2 | Write-1-to-clear for the flags |
| pkt_send_o | output | 1 | Send-packet request |
| pkt_len_o | output | XFER_W | Length of the requested packet |
| pkt_fifo_o | output | FIFO_ID_W | FIFO to read the packet from |
| ep_en_o | output | 1 | Endpoint enable state |
| target_odd_o | output | 1 | Target frame parity |
| cur_frame_o | output | FN_W | Frame number from the last SOF |
| xfer_left_o | output | XFER_W | Bytes still to send |
| pkt_left_o | output | PKT_W | Packets still to send |
| flags_o | output | 2 | Flags, bit0 complete, bit1 incomplete |
| xfer_irq_o | output | 1 | Masked transfer-complete interrupt |
| incomp_irq_o | output | 1 | Masked incomplete interrupt |

## Verification
If the captured frame parity or the target parity is wrong, the effect shows on the next token: a packet is sent in the wrong frame or no packet is sent in the right one. The same error also shows at the following SOF, where the incomplete flag is raised or withheld. Errors in the counters show on `pkt_len_o` within one cycle of a token, and on `xfer_left_o` and `pkt_left_o` at the same edge. A fault in the per-frame count shows as an extra send or a missing send within the same frame. A fault in the flag logic shows on `flags_o` and the interrupts one cycle after the event or the clear write.

// File: rtl/iso_sched_pkg.sv
package iso_sched_pkg;
  localparam logic [1:0] EP_TYPE_ISO = 2'd1;
  localparam int FLG_DONE = 0;
  localparam int FLG_MISS = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/iso_frame_track.sv
module iso_frame_track #(
  parameter int FN_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sof_i,
  input  logic [FN_W-1:0] frame_num_i,
  output logic [FN_W-1:0] cur_frame_o,
  output logic            frame_par_o
);
  logic [FN_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frame_q <= '0;
    else if (sof_i) frame_q <= frame_num_i;
  end

  assign cur_frame_o = frame_q;
  assign frame_par_o = frame_q[0];

  assert_frame_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> cur_frame_o == $past(frame_num_i));
endmodule

// File: rtl/iso_irq_flags.sv
module iso_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end
    assign irq_o[i] = flag_q[i] & mask_i[i];

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    assert_clr_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
    assert_irq_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> (mask_i[i] && flag_q[i]));
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/iso_ep_ctrl.sv
module iso_ep_ctrl
  import iso_sched_pkg::*;
#(
  parameter int MPS_W     = 11,
  parameter int XFER_W    = 13,
  parameter int PKT_W     = 3,
  parameter int MC_W      = 2,
  parameter int FIFO_ID_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic                 cfg_enable_i,
  input  logic                 cfg_active_i,
  input  logic                 cfg_cnak_i,
  input  logic                 cfg_set_even_i,
  input  logic                 cfg_set_odd_i,
  input  logic [1:0]           cfg_ep_type_i,
  input  logic [FIFO_ID_W-1:0] cfg_fifo_id_i,
  input  logic [MPS_W-1:0]     cfg_mps_i,
  input  logic [XFER_W-1:0]    cfg_xfer_size_i,
  input  logic [PKT_W-1:0]     cfg_pkt_cnt_i,
  input  logic [MC_W-1:0]      cfg_mc_i,
  input  logic                 sof_i,
  input  logic                 frame_par_i,
  input  logic                 in_token_i,
  input  logic                 in_token_err_i,
  input  logic [XFER_W-1:0]    fifo_bytes_i,
  output logic                 xfer_ev_o,
  output logic                 miss_ev_o,
  output logic                 pkt_send_o,
  output logic [XFER_W-1:0]    pkt_len_o,
  output logic [FIFO_ID_W-1:0] pkt_fifo_o,
  output logic                 ep_en_o,
  output logic                 target_odd_o,
  output logic [XFER_W-1:0]    xfer_left_o,
  output logic [PKT_W-1:0]     pkt_left_o
);
  localparam int CNT_W = MC_W + 1;

  logic                 en_q, tpar_q, active_q, nak_q;
  logic [1:0]           type_q;
  logic [FIFO_ID_W-1:0] fifo_q;
  logic [MPS_W-1:0]     mps_q;
  logic [XFER_W-1:0]    xfer_left_q;
  logic [PKT_W-1:0]     pkt_left_q;
  logic [MC_W-1:0]      mc_q;
  logic [CNT_W-1:0]     sent_q;
  logic                 pkt_send_q;
  logic [XFER_W-1:0]    pkt_len_q;

  logic [XFER_W-1:0] mps_ext, cur_len;
  logic [CNT_W-1:0]  limit;
  logic              eligible, room, fifo_ok, last_pkt, accept;

  always_comb begin
    mps_ext  = XFER_W'(mps_q);
    last_pkt = (pkt_left_q == PKT_W'(1));
    cur_len  = (last_pkt || xfer_left_q < mps_ext) ? xfer_left_q : mps_ext;
    limit    = (mc_q == '0) ? CNT_W'(1) : CNT_W'(mc_q);
    room     = sent_q < limit;
    fifo_ok  = fifo_bytes_i >= cur_len;
    eligible = en_q & active_q & ~nak_q & (type_q == EP_TYPE_ISO)
             & (tpar_q == frame_par_i) & (pkt_left_q != '0);
    accept   = in_token_i & ~in_token_err_i & ~sof_i & ~cfg_we_i
             & eligible & room & fifo_ok;
  end

  assign xfer_ev_o = accept & last_pkt;
  // frame_par_i still holds the parity of the frame that is ending
  assign miss_ev_o = sof_i & en_q & (tpar_q == frame_par_i) & ~cfg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      tpar_q      <= 1'b0;
      active_q    <= 1'b0;
      nak_q       <= 1'b1;
      type_q      <= '0;
      fifo_q      <= '0;
      mps_q       <= '0;
      xfer_left_q <= '0;
      pkt_left_q  <= '0;
      mc_q        <= '0;
      sent_q      <= '0;
      pkt_send_q  <= 1'b0;
      pkt_len_q   <= '0;
    end else begin
      pkt_send_q <= accept;
      if (accept) pkt_len_q <= cur_len;
      if (cfg_we_i) begin
        en_q        <= cfg_enable_i;
        active_q    <= cfg_active_i;
        type_q      <= cfg_ep_type_i;
        fifo_q      <= cfg_fifo_id_i;
        mps_q       <= cfg_mps_i;
        xfer_left_q <= cfg_xfer_size_i;
        pkt_left_q  <= cfg_pkt_cnt_i;
        mc_q        <= cfg_mc_i;
        sent_q      <= '0;
        if (cfg_cnak_i)          nak_q  <= 1'b0;
        if (cfg_set_even_i)      tpar_q <= 1'b0;
        else if (cfg_set_odd_i)  tpar_q <= 1'b1;
      end else begin
        if (sof_i) sent_q <= '0;
        if (miss_ev_o) en_q <= 1'b0;
        if (accept) begin
          xfer_left_q <= xfer_left_q - cur_len;
          pkt_left_q  <= pkt_left_q - PKT_W'(1);
          sent_q      <= sent_q + CNT_W'(1);
          if (last_pkt) en_q <= 1'b0;
        end
      end
    end
  end

  assign pkt_send_o   = pkt_send_q;
  assign pkt_len_o    = pkt_len_q;
  assign pkt_fifo_o   = fifo_q;
  assign ep_en_o      = en_q;
  assign target_odd_o = tpar_q;
  assign xfer_left_o  = xfer_left_q;
  assign pkt_left_o   = pkt_left_q;

  assert_send_parity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_send_q |-> $past(tpar_q == frame_par_i));
  assert_send_eligible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_send_q |-> $past(active_q && !nak_q && type_q == EP_TYPE_ISO));
  assert_fifo_cover_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_send_q |-> (pkt_len_q <= $past(fifo_bytes_i) && !$past(in_token_err_i)));
  assert_done_disables_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_ev_o && !cfg_we_i) |=> !en_q);
  assert_frame_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_send_q |-> sent_q <= limit);
  assert_miss_disables_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ev_o |=> !en_q);
endmodule

// File: rtl/iso_in_sched.sv
module iso_in_sched
  import iso_sched_pkg::*;
#(
  parameter int MPS_W     = 11,
  parameter int XFER_W    = 13,
  parameter int PKT_W     = 3,
  parameter int MC_W      = 2,
  parameter int FIFO_ID_W = 4,
  parameter int FN_W      = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic                 cfg_enable_i,
  input  logic                 cfg_active_i,
  input  logic                 cfg_cnak_i,
  input  logic                 cfg_set_even_i,
  input  logic                 cfg_set_odd_i,
  input  logic [1:0]           cfg_ep_type_i,
  input  logic [FIFO_ID_W-1:0] cfg_fifo_id_i,
  input  logic [MPS_W-1:0]     cfg_mps_i,
  input  logic [XFER_W-1:0]    cfg_xfer_size_i,
  input  logic [PKT_W-1:0]     cfg_pkt_cnt_i,
  input  logic [MC_W-1:0]      cfg_mc_i,
  input  logic                 sof_i,
  input  logic [FN_W-1:0]      frame_num_i,
  input  logic                 in_token_i,
  input  logic                 in_token_err_i,
  input  logic [XFER_W-1:0]    fifo_bytes_i,
  input  logic [1:0]           int_mask_i,
  input  logic [1:0]           int_clr_i,
  output logic                 pkt_send_o,
  output logic [XFER_W-1:0]    pkt_len_o,
  output logic [FIFO_ID_W-1:0] pkt_fifo_o,
  output logic                 ep_en_o,
  output logic                 target_odd_o,
  output logic [FN_W-1:0]      cur_frame_o,
  output logic [XFER_W-1:0]    xfer_left_o,
  output logic [PKT_W-1:0]     pkt_left_o,
  output logic [1:0]           flags_o,
  output logic                 xfer_irq_o,
  output logic                 incomp_irq_o
);
  logic                 frame_par;
  logic                 xfer_ev, miss_ev;
  logic [NUM_FLAGS-1:0] flag_set, irq;

  iso_frame_track #(.FN_W(FN_W)) i_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .frame_num_i (frame_num_i),
    .cur_frame_o (cur_frame_o),
    .frame_par_o (frame_par)
  );

  iso_ep_ctrl #(
    .MPS_W(MPS_W), .XFER_W(XFER_W), .PKT_W(PKT_W), .MC_W(MC_W), .FIFO_ID_W(FIFO_ID_W)
  ) i_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cfg_we_i        (cfg_we_i),
    .cfg_enable_i    (cfg_enable_i),
    .cfg_active_i    (cfg_active_i),
    .cfg_cnak_i      (cfg_cnak_i),
    .cfg_set_even_i  (cfg_set_even_i),
    .cfg_set_odd_i   (cfg_set_odd_i),
    .cfg_ep_type_i   (cfg_ep_type_i),
    .cfg_fifo_id_i   (cfg_fifo_id_i),
    .cfg_mps_i       (cfg_mps_i),
    .cfg_xfer_size_i (cfg_xfer_size_i),
    .cfg_pkt_cnt_i   (cfg_pkt_cnt_i),
    .cfg_mc_i        (cfg_mc_i),
    .sof_i           (sof_i),
    .frame_par_i     (frame_par),
    .in_token_i      (in_token_i),
    .in_token_err_i  (in_token_err_i),
    .fifo_bytes_i    (fifo_bytes_i),
    .xfer_ev_o       (xfer_ev),
    .miss_ev_o       (miss_ev),
    .pkt_send_o      (pkt_send_o),
    .pkt_len_o       (pkt_len_o),
    .pkt_fifo_o      (pkt_fifo_o),
    .ep_en_o         (ep_en_o),
    .target_odd_o    (target_odd_o),
    .xfer_left_o     (xfer_left_o),
    .pkt_left_o      (pkt_left_o)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_DONE] = xfer_ev;
    flag_set[FLG_MISS] = miss_ev;
  end

  iso_irq_flags #(.N(NUM_FLAGS)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (int_clr_i),
    .mask_i (int_mask_i),
    .flag_o (flags_o),
    .irq_o  (irq)
  );

  assign xfer_irq_o   = irq[FLG_DONE];
  assign incomp_irq_o = irq[FLG_MISS];
endmodule

// File: tb/test_iso_in_sched.sv
module test_iso_in_sched;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 0, cfg_enable_i = 0, cfg_active_i = 0, cfg_cnak_i = 0;
  logic        cfg_set_even_i = 0, cfg_set_odd_i = 0;
  logic [1:0]  cfg_ep_type_i = '0;
  logic [3:0]  cfg_fifo_id_i = '0;
  logic [10:0] cfg_mps_i = '0;
  logic [12:0] cfg_xfer_size_i = '0;
  logic [2:0]  cfg_pkt_cnt_i = '0;
  logic [1:0]  cfg_mc_i = '0;
  logic        sof_i = 0;
  logic [10:0] frame_num_i = '0;
  logic        in_token_i = 0, in_token_err_i = 0;
  logic [12:0] fifo_bytes_i = 13'd1000;
  logic [1:0]  int_mask_i = '0, int_clr_i = '0;
  logic        pkt_send_o;
  logic [12:0] pkt_len_o;
  logic [3:0]  pkt_fifo_o;
  logic        ep_en_o, target_odd_o;
  logic [10:0] cur_frame_o;
  logic [12:0] xfer_left_o;
  logic [2:0]  pkt_left_o;
  logic [1:0]  flags_o;
  logic        xfer_irq_o, incomp_irq_o;

  int checks = 0, failures = 0;
  bit done = 0;
  int exp_q[$];

  always #4 clk_i = ~clk_i;

  iso_in_sched i_iso_in_sched (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: each send request must match the next expected item
  always @(negedge clk_i) begin
    if (rst_ni && pkt_send_o) begin
      if (exp_q.size() == 0) chk(0, "R4 unexpected send", int'(pkt_len_o), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'({pkt_fifo_o, pkt_len_o}) == e, "R4 send len/fifo",
            int'({pkt_fifo_o, pkt_len_o}), e);
      end
    end
  end

  task automatic arm(input bit odd, input bit even, input int size, input int pkts,
                     input int mc, input int mps, input int fid, input int typ,
                     input bit act, input bit cnak, input bit en);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_enable_i = en; cfg_active_i = act; cfg_cnak_i = cnak;
    cfg_set_even_i = even; cfg_set_odd_i = odd; cfg_ep_type_i = 2'(typ);
    cfg_fifo_id_i = 4'(fid); cfg_mps_i = 11'(mps); cfg_xfer_size_i = 13'(size);
    cfg_pkt_cnt_i = 3'(pkts); cfg_mc_i = 2'(mc);
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic sof(input int fn, input bit [1:0] clr);
    @(negedge clk_i);
    sof_i = 1; frame_num_i = 11'(fn); int_clr_i = clr;
    @(negedge clk_i);
    sof_i = 0; int_clr_i = '0;
  endtask

  // exp < 0: no send expected; otherwise {fifo,len} pushed to scoreboard
  task automatic token(input bit err, input int exp);
    @(negedge clk_i);
    if (exp >= 0) exp_q.push_back(exp);
    in_token_i = 1; in_token_err_i = err;
    @(negedge clk_i);
    in_token_i = 0; in_token_err_i = 0;
  endtask

  task automatic clr(input bit [1:0] m);
    @(negedge clk_i); int_clr_i = m;
    @(negedge clk_i); int_clr_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(ep_en_o == 0 && flags_o == 0 && !xfer_irq_o && !incomp_irq_o && !pkt_send_o,
        "R1 reset state", int'({ep_en_o, flags_o}), 0);

    sof(2, 2'b00);
    chk(cur_frame_o == 11'd2, "R2 frame capture", int'(cur_frame_o), 2);
    // R3: NAK not yet cleared
    arm(0, 1, 10, 1, 1, 64, 3, 1, 1, 0, 1);
    token(0, -1);
    chk(xfer_left_o == 10 && ep_en_o, "R3 nak blocks", int'(xfer_left_o), 10);
    arm(0, 1, 10, 1, 1, 64, 3, 1, 0, 1, 1);   // inactive
    token(0, -1);
    chk(xfer_left_o == 10, "R3 inactive blocks", int'(xfer_left_o), 10);
    arm(0, 1, 10, 1, 1, 64, 3, 0, 1, 1, 1);   // type 0
    token(0, -1);
    chk(pkt_left_o == 1, "R3 non-iso blocks", int'(pkt_left_o), 1);

    // R2: arm odd during even frame
    arm(1, 0, 100, 1, 1, 128, 2, 1, 1, 1, 1);
    chk(target_odd_o == 1, "R2 set odd", int'(target_odd_o), 1);
    token(0, -1);
    chk(xfer_left_o == 100, "R2 wrong parity ignored", int'(xfer_left_o), 100);
    sof(3, 2'b00);
    chk(flags_o[1] == 0 && ep_en_o, "R8 no miss on other parity", int'(flags_o), 0);
    token(0, (2 << 13) | 100);
    chk(flags_o[0] == 1 && !ep_en_o, "R6 complete", int'({flags_o, ep_en_o}), 2);
    chk(xfer_left_o == 0, "R4 bytes drained", int'(xfer_left_o), 0);
    chk(!xfer_irq_o, "R10 masked", int'(xfer_irq_o), 0);
    @(negedge clk_i); int_mask_i = 2'b11;
    @(negedge clk_i);
    chk(xfer_irq_o && !incomp_irq_o, "R10 unmasked", int'({xfer_irq_o, incomp_irq_o}), 2);
    clr(2'b01);
    chk(flags_o == 0 && !xfer_irq_o, "R9 w1c", int'(flags_o), 0);

    // R4: three packets with remainder
    sof(4, 2'b00);
    arm(0, 1, 150, 3, 3, 64, 5, 1, 1, 1, 1);
    token(0, (5 << 13) | 64);
    chk(xfer_left_o == 86 && pkt_left_o == 2, "R4 counters", int'(xfer_left_o), 86);
    token(0, (5 << 13) | 64);
    token(0, (5 << 13) | 22);
    chk(flags_o[0] && !ep_en_o, "R6 multi complete", int'(flags_o), 1);
    clr(2'b01);

    // R7: one packet per frame
    sof(6, 2'b00);
    arm(0, 1, 128, 2, 1, 64, 1, 1, 1, 1, 1);
    token(0, (1 << 13) | 64);
    token(0, -1);
    chk(pkt_left_o == 1 && xfer_left_o == 64, "R7 per-frame limit", int'(pkt_left_o), 1);
    sof(7, 2'b00);
    chk(flags_o[1] && !ep_en_o, "R8 incomplete", int'({flags_o, ep_en_o}), 4);
    chk(incomp_irq_o, "R10 incomp irq", int'(incomp_irq_o), 1);
    clr(2'b10);
    chk(flags_o == 0, "R9 clear incomp", int'(flags_o), 0);

    // R5: FIFO short, then token error
    sof(8, 2'b00);
    arm(0, 1, 50, 1, 1, 64, 1, 1, 1, 1, 1);
    fifo_bytes_i = 13'd20;
    token(0, -1);
    chk(xfer_left_o == 50 && ep_en_o, "R5 fifo short", int'(xfer_left_o), 50);
    fifo_bytes_i = 13'd200;
    token(1, -1);
    chk(xfer_left_o == 50 && ep_en_o && pkt_left_o == 1, "R5 token error",
        int'(xfer_left_o), 50);
    sof(9, 2'b10);   // miss event and clear in same cycle
    chk(flags_o[1] && !ep_en_o, "R9 set wins", int'({flags_o, ep_en_o}), 4);
    clr(2'b10);

    arm(1, 1, 10, 1, 1, 64, 1, 1, 1, 1, 0);
    chk(target_odd_o == 0, "R2 even wins", int'(target_odd_o), 0);

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R4 all sends seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule